// File: doc/BRIEF.md
# Buffered Output Compare Channel Pair

This block drives timer output pins from two 16-bit compare channels that watch an external counter. Each channel owns a compare register, loaded one byte at a time from a host port, and a small control field. The field picks what a compare match does to the pin and whether the pin also toggles when the counter wraps. Unlinked, the two channels run independently, each on its own pin. Combining toggle-on-wrap with clear-on-match gives a PWM waveform whose high time is set by the compare value.

Setting the link bit in the even channel's control field turns the pair into one buffered channel that drives the even pin. The even register controls the pin first. After that, the register written most recently takes over, but only at a counter wrap, so software can load the next compare value into the idle register without glitching the current period. While the pair is linked, the odd channel's control field is ignored and the odd pin passes a general-purpose value through. A status output shows which register is active, so that software writes only the idle one. A write to the active register acts immediately, like an unbuffered compare.

The counter, its prescaler and bus decoding are outside the block. They arrive as a count value, an advance strobe and a wrap flag.

Top module: `bocp_pair`

## Requirements
- R1: A compare register is written as two bytes. A high-byte write (`wr_hi`=1) only stores the byte in a holding register. A low-byte write (`wr_hi`=0) loads the compare register with {held high byte, written low byte}. The held byte stays until it is written again.
- R2: On a cycle with `tick`=1 and `cnt` equal to the channel's active compare value, the pin takes the control field's action at the next clock edge. Action bits [1:0]: 0 = none, 1 = toggle, 2 = clear, 3 = set.
- R3: With control bit 2 set, the pin toggles on a cycle with `tick`=1 and `ovf`=1. When a compare action other than none occurs on the same cycle, only the compare action is applied.
- R4: On a cycle with `tick`=0, neither compare matches nor `ovf` change any pin.
- R5: With the link bit (bit 3 of the even control field) clear, each channel drives its own pin from its own compare register and control field.
- R6: When the link bit is set, the even compare register controls `pin_even` first and `active_odd` reads 0.
- R7: While linked, a write to the inactive register does not affect the current period. Control passes to that register at the next cycle with `tick` and `ovf` both high.
- R8: While linked, at each counter wrap the register whose low byte was written last becomes active. If neither register was written since the previous wrap, the active register does not change.
- R9: While linked, writing the active register changes the compare value used from the next cycle on, without waiting for a wrap.
- R10: While linked, `pin_odd` follows `gpio_odd`, and writes to the odd control field do not change `pin_even`.
- R11: Clearing the link bit returns the active selection to the even register and restores independent operation of both pins.
- R12: After reset both pins and `active_odd` are 0, both control fields are zero (unlinked, no action, no toggle), and both compare registers hold all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counter advances this cycle; qualifies matches and wraps |
| cnt | input | CNT_W (16) | Current counter value |
| ovf | input | 1 | Counter wraps this cycle |
| wr_en | input | 1 | Compare byte write strobe |
| wr_chan | input | 1 | Compare register select: 0 even, 1 odd |
| wr_hi | input | 1 | 1 = high byte (held), 0 = low byte (completes the write) |
| wr_byte | input | 8 | Write data byte |
| ctl_we | input | 1 | Control field write strobe |
| ctl_chan | input | 1 | Control field select: 0 even, 1 odd |
| ctl_byte | input | 4 | Control value: [3] link (even only), [2] toggle on wrap, [1:0] match action |
| gpio_odd | input | 1 | Value driven on the odd pin while linked |
| pin_even | output | 1 | Even channel output, or the buffered channel output |
| pin_odd | output | 1 | Odd channel output, or `gpio_odd` while linked |
| active_odd | output | 1 | 1 when the odd register controls the buffered output |

## Verification
The hardest situation to reach is a handover decided by write order inside one counter period. Both registers are written in the same period, the idle one first and then the active one. The correct result is that control stays with the active register even though a write to the idle one is pending. The bench gets there by placing two complete byte-pair writes at chosen counter values inside a single period. It then measures the high time of the following period, which gives the compare value that was in force. Every other handover is checked the same way, as a high-time count over whole periods, over a sweep of compare values against a small counter modulus.

// File: rtl/bocp_pkg.sv
package bocp_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CTL_W  = 4;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } oc_act_e;

    // bit 3 link, bit 2 toggle on wrap, bits 1:0 match action
    typedef struct packed {
        logic    link;
        logic    tov;
        oc_act_e act;
    } chan_ctl_t;

endpackage

// File: rtl/bocp_cmp_reg.sv
module bocp_cmp_reg
    import bocp_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              hi_sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  value,
    output logic              commit
);

    localparam int unsigned HI_W = CNT_W - BYTE_W;

    typedef struct packed {
        logic [HI_W-1:0]  hold;
        logic [CNT_W-1:0] value;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;
        if (we) begin
            if (hi_sel) begin
                st_d.hold = HI_W'(wdata);
            end else begin
                st_d.value = {st_q.hold, wdata};
                commit     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hold  <= '0;
            st_q.value <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.value;

endmodule

// File: rtl/bocp_buf_sel.sv
module bocp_buf_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic linked,
    input  logic wr_even,
    input  logic wr_odd,
    input  logic ovf_evt,
    output logic sel_odd
);

    typedef struct packed {
        logic sel;
        logic last;
        logic pend;
    } sel_st_t;

    sel_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!linked) begin
            st_d = '0;
        end else begin
            if (ovf_evt) begin
                if (st_q.pend) begin
                    st_d.sel = st_q.last;
                end
                st_d.pend = 1'b0;
            end
            // a write on the wrap cycle counts toward the following wrap
            if (wr_odd) begin
                st_d.last = 1'b1;
                st_d.pend = 1'b1;
            end else if (wr_even) begin
                st_d.last = 1'b0;
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_odd = st_q.sel;

endmodule

// File: rtl/bocp_oc_pin.sv
module bocp_oc_pin
    import bocp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      match,
    input  logic      ovf,
    input  chan_ctl_t ctl,
    output logic      pin
);

    logic pin_d, pin_q;

    always_comb begin
        pin_d = pin_q;
        if (tick) begin
            if (match && (ctl.act != ACT_NONE)) begin
                unique case (ctl.act)
                    ACT_TOGGLE: pin_d = ~pin_q;
                    ACT_CLEAR:  pin_d = 1'b0;
                    ACT_SET:    pin_d = 1'b1;
                    default:    pin_d = pin_q;
                endcase
            end else if (ovf && ctl.tov) begin
                pin_d = ~pin_q;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign pin = pin_q;

endmodule

// File: rtl/bocp_pair.sv
module bocp_pair
    import bocp_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              ovf,
    input  logic              wr_en,
    input  logic              wr_chan,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              ctl_we,
    input  logic              ctl_chan,
    input  logic [CTL_W-1:0]  ctl_byte,
    input  logic              gpio_odd,
    output logic              pin_even,
    output logic              pin_odd,
    output logic              active_odd
);

    localparam int unsigned NCH = 2;

    typedef struct packed {
        chan_ctl_t [NCH-1:0] ctl;
    } top_st_t;

    top_st_t st_d, st_q;

    logic             linked;
    logic             sel_odd;
    logic [CNT_W-1:0] cmp_val [NCH];
    logic [NCH-1:0]   cmp_commit;
    logic [NCH-1:0]   pin_q;
    logic [CNT_W-1:0] lead_ref;

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            st_d.ctl[ctl_chan] = chan_ctl_t'(ctl_byte);
            if (ctl_chan) begin
                st_d.ctl[1].link = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign linked = st_q.ctl[0].link;

    bocp_buf_sel u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .linked  (linked),
        .wr_even (cmp_commit[0]),
        .wr_odd  (cmp_commit[1]),
        .ovf_evt (tick && ovf),
        .sel_odd (sel_odd)
    );

    always_comb begin
        lead_ref = linked ? cmp_val[sel_odd] : cmp_val[0];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic ch_tick;
        logic ch_match;

        bocp_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (wr_en && (wr_chan == 1'(g))),
            .hi_sel (wr_hi),
            .wdata  (wr_byte),
            .value  (cmp_val[g]),
            .commit (cmp_commit[g])
        );

        if (g == 0) begin : g_lead
            assign ch_tick  = tick;
            assign ch_match = (cnt == lead_ref);
        end else begin : g_follow
            assign ch_tick  = tick && !linked;
            assign ch_match = (cnt == cmp_val[g]);
        end

        bocp_oc_pin u_pin (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (ch_tick),
            .match (ch_match),
            .ovf   (ovf),
            .ctl   (st_q.ctl[g]),
            .pin   (pin_q[g])
        );
    end

    assign pin_even   = pin_q[0];
    assign pin_odd    = linked ? gpio_odd : pin_q[1];
    assign active_odd = sel_odd;

endmodule

// File: rtl/bocp_pair_chk.sv
module bocp_pair_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic ovf,
    input logic linked,
    input logic active_odd,
    input logic pin_even
);

    // R4: pins only move on counter advance
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pin_even));

    // R6: the even register leads right after linking
    assert_link_even_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(linked) |-> !active_odd);

    // R7: the odd register takes control only on a wrap
    assert_handover_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_odd) |-> $past(tick && ovf));

    // R8: selection holds between wraps while linked
    assert_sel_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (linked && !(tick && ovf)) |=> (!linked || $stable(active_odd)));

    // R11: unlinking returns the selection to even
    assert_unlink_even_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(linked) |=> !active_odd);

endmodule

bind bocp_pair bocp_pair_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .ovf        (ovf),
    .linked     (linked),
    .active_odd (active_odd),
    .pin_even   (pin_even)
);

// File: tb/bocp_pair_tb_top.sv
module bocp_pair_tb_top;

    localparam int CNT_W = 16;
    localparam int M     = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic [CNT_W-1:0] cnt = '0;
    logic             ovf = 1'b0;
    logic             wr_en = 1'b0;
    logic             wr_chan = 1'b0;
    logic             wr_hi = 1'b0;
    logic [7:0]       wr_byte = '0;
    logic             ctl_we = 1'b0;
    logic             ctl_chan = 1'b0;
    logic [3:0]       ctl_byte = '0;
    logic             gpio_odd = 1'b0;
    logic             pin_even, pin_odd, active_odd;

    always #10 clk = ~clk;

    bocp_pair #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .ovf(ovf),
        .wr_en(wr_en), .wr_chan(wr_chan), .wr_hi(wr_hi), .wr_byte(wr_byte),
        .ctl_we(ctl_we), .ctl_chan(ctl_chan), .ctl_byte(ctl_byte),
        .gpio_odd(gpio_odd), .pin_even(pin_even), .pin_odd(pin_odd),
        .active_odd(active_odd)
    );

    int errs = 0;
    int checks = 0;
    int cv = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic tk);
        @(negedge clk);
        tick = tk;
        cnt  = CNT_W'(cv);
        ovf  = (cv == M);
        @(posedge clk);
        #2;
        wr_en  = 1'b0;
        ctl_we = 1'b0;
        if (tk) cv = (cv == M) ? 0 : cv + 1;
    endtask

    task automatic wr_byte_only(input logic ch, input logic hi, input logic [7:0] b);
        wr_en = 1'b1; wr_chan = ch; wr_hi = hi; wr_byte = b;
        step(1'b1);
    endtask

    task automatic wr_full(input logic ch, input logic [15:0] v);
        wr_byte_only(ch, 1'b1, v[15:8]);
        wr_byte_only(ch, 1'b0, v[7:0]);
    endtask

    task automatic ctl_wr(input logic ch, input logic [3:0] v);
        ctl_we = 1'b1; ctl_chan = ch; ctl_byte = v;
        step(1'b1);
    endtask

    task automatic align();
        while (cv != M) step(1'b1);
    endtask

    // one full period starting with the wrap; up to two full writes inside
    task automatic window(input int at1, input logic c1, input logic [15:0] v1,
                          input int at2, input logic c2, input logic [15:0] v2,
                          output int he, output int ho);
        he = 0; ho = 0;
        align();
        for (int i = 0; i <= M; i++) begin
            if (at1 >= 0 && cv == at1) begin
                wr_en = 1'b1; wr_chan = c1; wr_hi = 1'b1; wr_byte = v1[15:8];
            end else if (at1 >= 0 && cv == at1 + 1) begin
                wr_en = 1'b1; wr_chan = c1; wr_hi = 1'b0; wr_byte = v1[7:0];
            end else if (at2 >= 0 && cv == at2) begin
                wr_en = 1'b1; wr_chan = c2; wr_hi = 1'b1; wr_byte = v2[15:8];
            end else if (at2 >= 0 && cv == at2 + 1) begin
                wr_en = 1'b1; wr_chan = c2; wr_hi = 1'b0; wr_byte = v2[7:0];
            end
            step(1'b1);
            he += int'(pin_even);
            ho += int'(pin_odd);
        end
    endtask

    task automatic idle(output int he, output int ho);
        window(-1, 1'b0, 16'd0, -1, 1'b0, 16'd0, he, ho);
    endtask

    initial begin
        #(20 * 150000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int he, ho, h1, h2, a;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R12 reset state
        chk("R12 pin_even", int'(pin_even), 0);
        chk("R12 pin_odd", int'(pin_odd), 0);
        chk("R12 active_odd", int'(active_odd), 0);
        idle(he, ho);
        chk("R12 no action after reset even", he, 0);
        chk("R12 no action after reset odd", ho, 0);

        // R5 / R2: independent channels, even clear+wrap toggle, odd set+wrap toggle
        ctl_wr(1'b0, 4'b0110);
        ctl_wr(1'b1, 4'b0111);
        for (int c = 0; c < M; c++) begin
            wr_full(1'b0, 16'(c));
            wr_full(1'b1, 16'(M - 1 - c));
            idle(he, ho);
            idle(he, ho);
            chk("R5 even high time", he, c + 1);
            chk("R2 odd set high time", ho, c + 1);
        end

        // R1 byte assembly
        wr_full(1'b0, 16'd3);
        idle(he, ho);
        idle(he, ho);
        wr_byte_only(1'b0, 1'b1, 8'h01);
        idle(he, ho);
        chk("R1 high byte alone no effect", he, 4);
        wr_byte_only(1'b0, 1'b0, 8'h06);
        idle(h1, ho);
        idle(h2, ho);
        chk("R1 held high byte used", h1 + h2, M + 1);
        wr_full(1'b0, 16'd6);
        idle(he, ho);
        idle(he, ho);
        chk("R1 full write", he, 7);

        // R6 / R10 linking
        wr_full(1'b0, 16'd4);
        ctl_wr(1'b0, 4'b1110);
        chk("R6 active even after link", int'(active_odd), 0);
        gpio_odd = 1'b1;
        idle(he, ho);
        idle(he, ho);
        chk("R6 even controls first", he, 5);
        chk("R10 odd pin follows gpio high", ho, M + 1);
        gpio_odd = 1'b0;
        ctl_wr(1'b1, 4'b0011);
        idle(he, ho);
        chk("R10 odd control ignored", he, 5);
        chk("R10 odd pin follows gpio low", ho, 0);

        // R7 / R8 handover sweep
        a = 4;
        for (int i = 0; i < 5; i++) begin
            int b, a2;
            b  = (2 * i + 3) % M;
            a2 = (b + 4) % M;
            window(0, 1'b1, 16'(b), -1, 1'b0, 16'd0, he, ho);
            chk("R7 odd write waits for wrap", he, a + 1);
            chk("R7 still even", int'(active_odd), 0);
            window(0, 1'b0, 16'(a2), -1, 1'b0, 16'd0, he, ho);
            chk("R8 odd active after wrap", he, b + 1);
            chk("R8 active_odd set", int'(active_odd), 1);
            idle(he, ho);
            chk("R8 even back after wrap", he, a2 + 1);
            chk("R8 active_odd clear", int'(active_odd), 0);
            idle(he, ho);
            chk("R8 no write keeps selection", he, a2 + 1);
            a = a2;
        end

        // R8 last writer wins within one period
        window(0, 1'b1, 16'd8, 4, 1'b0, 16'd6, he, ho);
        idle(he, ho);
        chk("R8 last written even stays", he, 7);
        chk("R8 last written even flag", int'(active_odd), 0);

        // R9 write to active register
        window(0, 1'b0, 16'd2, -1, 1'b0, 16'd0, he, ho);
        chk("R9 active write immediate", he, 3);

        // R3 compare and wrap on the same cycle
        wr_full(1'b0, 16'(M));
        idle(he, ho);
        idle(he, ho);
        chk("R3 clear beats toggle", he, 0);
        ctl_wr(1'b0, 4'b1111);
        idle(he, ho);
        idle(he, ho);
        chk("R3 set beats toggle", he, M + 1);

        // R4 no action without tick
        ctl_wr(1'b0, 4'b1110);
        wr_full(1'b0, 16'd5);
        idle(he, ho);
        idle(he, ho);
        align();
        while (cv != 5) step(1'b1);
        chk("R4 pin high before match", int'(pin_even), 1);
        step(1'b0);
        chk("R4 match ignored without tick", int'(pin_even), 1);
        step(1'b1);
        chk("R2 clear on match", int'(pin_even), 0);

        // R11 unlink
        window(0, 1'b1, 16'd5, -1, 1'b0, 16'd0, he, ho);
        idle(he, ho);
        chk("R11 odd active before unlink", int'(active_odd), 1);
        ctl_wr(1'b0, 4'b0110);
        step(1'b1);
        chk("R11 active back to even", int'(active_odd), 0);
        idle(he, ho);
        idle(he, ho);
        chk("R11 even independent", he, 6);
        chk("R11 odd independent set", ho, M + 1);

        // R6 relink with different odd value
        wr_full(1'b1, 16'd9);
        ctl_wr(1'b0, 4'b1110);
        step(1'b1);
        chk("R6 relink even active", int'(active_odd), 0);
        idle(he, ho);
        idle(he, ho);
        chk("R6 relink even controls", he, 6);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule